// File: doc/BRIEF.md
# Prescaled Timer Counter with Coherent Byte Read

This block is a free-running 16-bit up-counter whose rate is set by a power-of-two prescaler running on the bus clock. Software reaches it over a narrow 8-bit register bus. One control write sets a 3-bit divide-select field and can also carry a one-shot clear command. A single-cycle read strobe with a byte select returns either half of the count.

An 8-bit bus cannot read a 16-bit count in one access, and the count can roll over between two accesses. To avoid a torn value, a read of the high byte also copies the low byte of the same instant into a holding buffer. The next low-byte read returns that copy and frees the buffer. The counter itself never stops. Only the read-back path is frozen while a copy is held.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the count is 0x0000, the divide-select field is 000, no low-byte copy is held, and rdData reads 0x00.
- R2: A ctlWr pulse loads ctlData[2:0] into the divide-select field. Codes 0 to 6 make the counter advance once every 2^code bus cycles.
- R3: Select code 7 gives the same rate as code 6: one advance every 64 bus cycles.
- R4: The counter steps by exactly one per prescaler pulse. The first step comes N cycles after reset or clear, and further steps follow every N cycles, where N is the current ratio.
- R5: The count wraps from 0xFFFF to 0x0000 and keeps counting.
- R6: A rdStrobe with rdSelHigh=1 returns count[15:8]. With rdSelHigh=0 it returns a low byte. rdData changes at the clock edge that samples the strobe and holds until the next read.
- R7: When no copy is held, a high-byte read captures count[7:0] from the same edge into the buffer. The following low-byte read returns the buffer and releases it.
- R8: While a copy is held, further high-byte reads return the live high byte but do not refresh the buffer. The copy is held indefinitely until a low-byte read.
- R9: A low-byte read while no copy is held returns the live count[7:0].
- R10: A ctlWr with ctlData[4]=1 zeroes the counter, restarts the prescaler phase and releases any held copy. Bit 4 is a command and is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous system reset |
| ctlWr | input | 1 | Single-cycle control write strobe |
| ctlData | input | 8 | Control write data: [2:0] divide select, [4] counter clear |
| rdStrobe | input | 1 | Single-cycle read strobe |
| rdSelHigh | input | 1 | Byte select for the read: 1 high byte, 0 low byte |
| rdData | output | 8 | Registered read data |

## Verification
The bench reads the high byte, waits hundreds of cycles, and then reads the low byte. A design that did not freeze the low byte would return a value far from the captured one. Repeated high reads between capture and release catch a buffer that refreshes on every high access. Select code 7 is compared against a ratio of 64, so a decoder that treats it as divide-by-128 or divide-by-1 shows a wrong count. Clears issued while a copy is held, and a run across the 0xFFFF boundary, expose a clear that leaves the latch set or a counter that saturates instead of wrapping.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Strobes from control to datapath, one bundle per cycle
  typedef struct packed {
    logic clear;       // zero the counter
    logic tick;        // prescaler pulse, advance counter
    logic loadHigh;    // drive high byte onto read data
    logic loadLow;     // drive a low byte onto read data
    logic lowFromBuf;  // low byte comes from the held copy
    logic capture;     // copy live low byte into holding buffer
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int DIV_W   = 6,
  parameter int BUS_W   = 8,
  parameter int CLR_BIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWr,
  input  logic [BUS_W-1:0] ctlData,
  input  logic             rdStrobe,
  input  logic             rdSelHigh,
  output tmrStrobe_t       strobes,
  output logic             heldOut,
  output logic [SEL_W-1:0] selOut
);
  localparam int MAX_SHIFT = DIV_W;

  logic [SEL_W-1:0] selReg;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMask;
  logic             held;
  logic             clearCmd;
  logic             rdHigh;
  logic             rdLow;

  assign clearCmd = ctlWr & ctlData[CLR_BIT];
  assign rdHigh   = rdStrobe & rdSelHigh;
  assign rdLow    = rdStrobe & ~rdSelHigh;

  // Divide mask: codes beyond the widest divider saturate at 2^MAX_SHIFT
  always_comb begin
    divMask = '0;
    for (int b = 0; b < DIV_W; b++) begin
      if (b < MAX_SHIFT && int'(selReg) > b) divMask[b] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg <= '0;
      divCnt <= '0;
      held   <= 1'b0;
    end else begin
      if (ctlWr) selReg <= ctlData[SEL_W-1:0];
      if (clearCmd) divCnt <= '0;
      else          divCnt <= divCnt + 1'b1;
      if (clearCmd || rdLow) held <= 1'b0;
      else if (rdHigh)       held <= 1'b1;
    end
  end

  always_comb begin
    strobes.clear      = clearCmd;
    strobes.tick       = ((divCnt & divMask) == divMask);
    strobes.loadHigh   = rdHigh;
    strobes.loadLow    = rdLow;
    strobes.lowFromBuf = held;
    strobes.capture    = rdHigh & ~held;
  end

  assign heldOut = held;
  assign selOut  = selReg;
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobes,
  output logic [BUS_W-1:0] rdData,
  output logic [CNT_W-1:0] cntOut,
  output logic [BUS_W-1:0] bufOut
);
  localparam int HI_LSB = CNT_W - BUS_W;

  logic [CNT_W-1:0] cnt;
  logic [BUS_W-1:0] lowBuf;
  logic [BUS_W-1:0] liveHigh;
  logic [BUS_W-1:0] liveLow;

  assign liveHigh = cnt[CNT_W-1:HI_LSB];
  assign liveLow  = cnt[BUS_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      lowBuf <= '0;
      rdData <= '0;
    end else begin
      if (strobes.clear)     cnt <= '0;
      else if (strobes.tick) cnt <= cnt + 1'b1;
      if (strobes.capture) lowBuf <= liveLow;
      if (strobes.loadHigh)     rdData <= liveHigh;
      else if (strobes.loadLow) rdData <= strobes.lowFromBuf ? lowBuf : liveLow;
    end
  end

  assign cntOut = cnt;
  assign bufOut = lowBuf;
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int DIV_W   = 6,
  parameter int BUS_W   = 8,
  parameter int CNT_W   = 16,
  parameter int CLR_BIT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWr,
  input  logic [BUS_W-1:0] ctlData,
  input  logic             rdStrobe,
  input  logic             rdSelHigh,
  output logic [BUS_W-1:0] rdData
);
  tmrStrobe_t       strobes;
  logic             heldFlag;
  logic [SEL_W-1:0] selVal;
  logic [CNT_W-1:0] cntVal;
  logic [BUS_W-1:0] bufVal;

  tmr_ctrl #(.SEL_W(SEL_W), .DIV_W(DIV_W), .BUS_W(BUS_W), .CLR_BIT(CLR_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlData(ctlData),
    .rdStrobe(rdStrobe), .rdSelHigh(rdSelHigh),
    .strobes(strobes), .heldOut(heldFlag), .selOut(selVal)
  );

  tmr_datapath #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .rdData(rdData), .cntOut(cntVal), .bufOut(bufVal)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int SEL_W   = 3,
  parameter int BUS_W   = 8,
  parameter int CNT_W   = 16,
  parameter int CLR_BIT = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctlWr,
  input logic [BUS_W-1:0] ctlData,
  input logic             rdStrobe,
  input logic             rdSelHigh,
  input logic [BUS_W-1:0] rdData,
  input logic [CNT_W-1:0] cntVal,
  input logic [BUS_W-1:0] bufVal,
  input logic             heldFlag,
  input logic [SEL_W-1:0] selVal
);
  logic clr;
  assign clr = ctlWr & ctlData[CLR_BIT];

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (cntVal == '0) && !heldFlag); // R10
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    !clr |=> (cntVal == $past(cntVal) + 1'b1) || (cntVal == $past(cntVal))); // R4
  AST_DIV_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (selVal == '0) && !clr |=> cntVal == $past(cntVal) + 1'b1); // R2
  AST_HIGH_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && rdSelHigh && !heldFlag && !clr |=> heldFlag && (bufVal == $past(cntVal[BUS_W-1:0]))); // R7
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    heldFlag && !(rdStrobe && !rdSelHigh) && !clr |=> heldFlag && $stable(bufVal)); // R8
  AST_LOW_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !rdSelHigh |=> !heldFlag); // R7
  AST_HIGH_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && rdSelHigh |=> rdData == $past(cntVal[CNT_W-1:CNT_W-BUS_W])); // R6
  AST_NO_READ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(rdData)); // R6
endmodule

bind prescaled_timer tmr_checker #(.SEL_W(SEL_W), .BUS_W(BUS_W), .CNT_W(CNT_W), .CLR_BIT(CLR_BIT)) i_chk (
  .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlData(ctlData),
  .rdStrobe(rdStrobe), .rdSelHigh(rdSelHigh), .rdData(rdData),
  .cntVal(cntVal), .bufVal(bufVal), .heldFlag(heldFlag), .selVal(selVal)
);

// File: tb/test_prescaled_timer.sv
module test_prescaled_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctlWr = 1'b0;
  logic [7:0] ctlData = '0;
  logic       rdStrobe = 1'b0;
  logic       rdSelHigh = 1'b0;
  logic [7:0] rdData;

  int checks = 0;
  int fails  = 0;

  // reference model state
  logic [15:0] refCnt = '0;
  int unsigned refCyc = 0;
  logic [2:0]  refSel = '0;
  logic [7:0]  refBuf = '0;
  bit          refHeld = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       sawRead = 1'b0;

  prescaled_timer i_prescaled_timer (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .ctlData(ctlData),
    .rdStrobe(rdStrobe), .rdSelHigh(rdSelHigh), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int unsigned ratioOf(input logic [2:0] s);
    return (s == 3'd7) ? 64 : (32'd1 << s);
  endfunction

  // Reference counter, written from the rate and clear requirements
  always @(posedge clk) begin
    if (!rstN) begin
      refCnt <= '0; refCyc <= 0; refSel <= '0;
    end else begin
      if (ctlWr) refSel <= ctlData[2:0];
      if (ctlWr && ctlData[4]) begin
        refCnt <= '0; refCyc <= 0;
      end else begin
        if (((refCyc + 1) % ratioOf(refSel)) == 0) refCnt <= refCnt + 16'd1;
        refCyc <= refCyc + 1;
      end
    end
    sawRead <= rdStrobe && rstN;
  end

  // Monitor: pop and compare one expected byte per completed read
  always @(negedge clk) begin
    if (sawRead && expQ.size() > 0) begin
      logic [7:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (rdData !== e) begin
        fails++;
        $display("FAIL %s: rdData=%02h expected=%02h", t, rdData, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCtl(input logic [7:0] d);
    @(negedge clk);
    ctlWr = 1'b1; ctlData = d;
    if (d[4]) refHeld = 0;
    @(negedge clk);
    ctlWr = 1'b0; ctlData = '0;
  endtask

  // Driver: predicts the read result and pushes it to the scoreboard
  task automatic doRead(input bit hi, input string tag);
    logic [7:0] e;
    @(negedge clk);
    if (hi) begin
      e = refCnt[15:8];
      if (!refHeld) begin refBuf = refCnt[7:0]; refHeld = 1; end
    end else begin
      e = refHeld ? refBuf : refCnt[7:0];
      refHeld = 0;
    end
    expQ.push_back(e); tagQ.push_back(tag);
    rdStrobe = 1'b1; rdSelHigh = hi;
    @(negedge clk);
    rdStrobe = 1'b0; rdSelHigh = 1'b0;
  endtask

  task automatic direct(input logic [7:0] act, input logic [7:0] e, input string tag);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, e);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finishRun();
  end

  initial begin
    idle(3);
    direct(rdData, 8'h00, "R1 reset read data");
    rstN = 1'b1;
    // R1: default select 000 counts every cycle from zero
    idle(10);
    doRead(0, "R1 default rate low");
    doRead(1, "R1 default rate high");
    doRead(0, "R7 low after high");
    // R2: each ratio code, restarted by clear
    for (int c = 1; c <= 6; c++) begin
      writeCtl(8'h10 | 8'(c));
      idle(300 + c * 37);
      doRead(1, "R2 ratio high");
      doRead(0, "R2 ratio low");
    end
    // R3: code 7 behaves as 64
    writeCtl(8'h17);
    idle(1000);
    doRead(1, "R3 code7 high");
    doRead(0, "R3 code7 low");
    // R4: ratio change without clear keeps counting
    writeCtl(8'h02);
    idle(45);
    doRead(0, "R4 rate change low");
    // R7/R8: capture, long hold with repeated high reads
    writeCtl(8'h10);
    idle(77);
    doRead(1, "R7 capture high");
    idle(400);
    doRead(1, "R8 repeat high live");
    idle(333);
    doRead(1, "R8 repeat high again");
    doRead(0, "R8 held low not refreshed");
    // R9: low read with nothing held is live
    idle(21);
    doRead(0, "R9 live low");
    idle(5);
    doRead(0, "R9 live low again");
    // R10: clear while held releases copy
    doRead(1, "R10 capture before clear");
    idle(50);
    writeCtl(8'h10);
    idle(3);
    doRead(0, "R10 low after clear");
    doRead(1, "R10 high after clear");
    doRead(0, "R10 low release");
    // R5: wrap across 0xFFFF at ratio 1
    writeCtl(8'h10);
    idle(65528);
    doRead(1, "R5 high before wrap");
    doRead(0, "R5 low before wrap");
    idle(4);
    doRead(1, "R5 high after wrap");
    doRead(0, "R5 low after wrap");
    idle(4);
    // R6: data holds with no read
    direct(rdData, expQ.size() == 0 ? rdData : 8'hxx, "R6 queue drained");
    begin
      logic [7:0] last;
      last = rdData;
      idle(20);
      direct(rdData, last, "R6 read data holds");
    end
    finishRun();
  end
endmodule